// File: doc/BRIEF.md
# Strip-mining vector register DMA engine

This engine sits between a large private vector register memory and one pair of vector lanes. At the start of each vector instruction it takes one configuration: the segment base addresses of up to two source registers and of the destination register, the vector length in bytes, and how many sources the instruction reads. It then streams the operand vector to the lanes one segment per cycle. The lanes work on the segment they hold while the engine fetches the next one from memory. This loop runs until the whole vector length has been covered.

A separate write channel takes result segments from the lanes and stores them into the destination register, one segment per accepted handshake. The last segment of a vector whose length is not a whole number of segments is partial, and a per-byte mask marks its active bytes on both channels. When both channels have finished, the engine raises a one-cycle completion pulse and becomes idle again. A unit with sixteen lanes uses eight of these engines. The register memory is addressed in whole segments and answers a read in the same cycle.

Top module: `smdma_top`

## Requirements
- R1: A configuration presented with `cfg_valid` while the engine is idle is accepted. The first read segment comes from address `cfg_src0_base` and the first write goes to `cfg_dst_base`. While the engine is idle, `lane_valid` and `res_ready` stay low.
- R2: `cfg_valid` while the engine is busy is ignored: the transfers in progress continue with their original addresses, and `cfg_reject` is high in the following cycle only.
- R3: `cfg_src_mode` 0 reads no source, 1 reads source 0 only (`mem_rd_en1` stays low and `lane_seg1` is zero), and 2 reads both sources in lockstep. In mode 2 both segments are presented in the same cycle under one `lane_valid`.
- R4: The segment count is ceil(`cfg_vlen` / SEG_BYTES). Read segment k of source s comes from memory address base_s + k, modulo 2^AW, with k counting up from 0.
- R5: `lane_mask` and `mem_wr_mask` are all ones, except on the last segment when `cfg_vlen` mod SEG_BYTES = r is nonzero. In that case only bits r-1..0 (bytes 0 to r-1) are set.
- R6: While `lane_valid` is high and `lane_ready` is low, the segment and mask are held. No segment is dropped or repeated.
- R7: With `lane_ready` held high, read segments are delivered on back-to-back cycles once the first one appears.
- R8: `res_ready` is high while write segments remain. Each accepted result k is written at `cfg_dst_base` + k in the same cycle. The write address advances only on an accepted result.
- R9: `done` is high for exactly one cycle, two cycles after the later of the final read handshake and the final write handshake. With a zero length, `done` is high in the second cycle after the configuration edge.
- R10: Out of reset, `lane_valid`, `res_ready`, `done`, `cfg_reject`, `mem_rd_en0`, `mem_rd_en1` and `mem_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_valid | input | 1 | Configuration request |
| cfg_src_mode | input | 2 | Number of source operands (0, 1, 2) |
| cfg_src0_base | input | AW | Segment base of source 0 |
| cfg_src1_base | input | AW | Segment base of source 1 |
| cfg_dst_base | input | AW | Segment base of destination |
| cfg_vlen | input | LEN_W | Vector length in bytes |
| cfg_reject | output | 1 | Configuration arrived while busy |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en0 | output | 1 | Source 0 memory read strobe |
| mem_rd_addr0 | output | AW | Source 0 segment address |
| mem_rd_data0 | input | SEG_BYTES*8 | Source 0 read data, same cycle |
| mem_rd_en1 | output | 1 | Source 1 memory read strobe |
| mem_rd_addr1 | output | AW | Source 1 segment address |
| mem_rd_data1 | input | SEG_BYTES*8 | Source 1 read data, same cycle |
| lane_valid | output | 1 | Operand segments valid |
| lane_ready | input | 1 | Lanes accept operand segments |
| lane_seg0 | output | SEG_BYTES*8 | Source 0 segment |
| lane_seg1 | output | SEG_BYTES*8 | Source 1 segment |
| lane_mask | output | SEG_BYTES | Active bytes of operand segment |
| res_valid | input | 1 | Lane result segment valid |
| res_ready | output | 1 | Engine accepts a result segment |
| res_data | input | SEG_BYTES*8 | Lane result segment |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | AW | Destination segment address |
| mem_wr_data | output | SEG_BYTES*8 | Write data |
| mem_wr_mask | output | SEG_BYTES | Byte enables of the write |

## Verification
The hardest case to reach is a reconfiguration attempt in the middle of a transfer. The request has to arrive while the read and write channels are both mid-stream, so that its addresses would visibly corrupt the segments still to come. The bench injects a request with different bases two cycles into a long two-source transfer that runs under alternating lane backpressure. It then checks that every later segment still comes from the original bases. Lengths from zero to five segments, all three source modes and three ready/valid patterns are swept, which covers every partial-segment mask and every timing of completion relative to the two channels.

// File: rtl/smdma_pkg.sv
package smdma_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_ONE  = 2'd1,
        SRC_TWO  = 2'd2
    } src_mode_e;
endpackage

// File: rtl/smdma_tail_mask.sv
module smdma_tail_mask #(
    parameter int SEG_BYTES = 64,
    localparam int OFF_W = $clog2(SEG_BYTES)
) (
    input  logic                 is_last,
    input  logic [OFF_W-1:0]     tail,
    output logic [SEG_BYTES-1:0] mask
);
    for (genvar b = 0; b < SEG_BYTES; b++) begin : g_byte
        localparam logic [OFF_W:0] BIDX = b;
        assign mask[b] = !is_last || (tail == '0) || ({1'b0, tail} > BIDX);
    end
endmodule

// File: rtl/smdma_rd_chan.sv
module smdma_rd_chan
    import smdma_pkg::*;
#(
    parameter int SEG_BYTES = 64,
    parameter int AW        = 12,
    parameter int NW        = 11,
    localparam int SEG_W    = SEG_BYTES * 8,
    localparam int OFF_W    = $clog2(SEG_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  src_mode_e            mode,
    input  logic [NW-1:0]        nseg,
    input  logic [OFF_W-1:0]     tail,
    input  logic [AW-1:0]        base0,
    input  logic [AW-1:0]        base1,
    output logic                 mem_rd_en0,
    output logic [AW-1:0]        mem_rd_addr0,
    input  logic [SEG_W-1:0]     mem_rd_data0,
    output logic                 mem_rd_en1,
    output logic [AW-1:0]        mem_rd_addr1,
    input  logic [SEG_W-1:0]     mem_rd_data1,
    output logic                 lane_valid,
    input  logic                 lane_ready,
    output logic [SEG_W-1:0]     lane_seg0,
    output logic [SEG_W-1:0]     lane_seg1,
    output logic [SEG_BYTES-1:0] lane_mask,
    output logic                 rd_idle
);
    typedef struct packed {
        logic [NW-1:0]        left;
        logic [NW-1:0]        idx;
        logic                 two;
        logic [AW-1:0]        base0;
        logic [AW-1:0]        base1;
        logic [OFF_W-1:0]     tail;
        logic                 valid;
        logic [SEG_W-1:0]     d0;
        logic [SEG_W-1:0]     d1;
        logic [SEG_BYTES-1:0] mask;
    } rd_state_t;

    rd_state_t            s_d, s_q;
    logic                 load;
    logic [SEG_BYTES-1:0] next_mask;

    smdma_tail_mask #(.SEG_BYTES(SEG_BYTES)) u_mask (
        .is_last (s_q.left == NW'(1)),
        .tail    (s_q.tail),
        .mask    (next_mask)
    );

    always_comb begin
        s_d  = s_q;
        load = (s_q.left != '0) && (!s_q.valid || lane_ready);
        if (start) begin
            s_d.left  = (mode == SRC_NONE) ? '0 : nseg;
            s_d.idx   = '0;
            s_d.two   = (mode == SRC_TWO);
            s_d.base0 = base0;
            s_d.base1 = base1;
            s_d.tail  = tail;
            s_d.valid = 1'b0;
        end else if (load) begin
            s_d.valid = 1'b1;
            s_d.d0    = mem_rd_data0;
            s_d.d1    = s_q.two ? mem_rd_data1 : '0;
            s_d.mask  = next_mask;
            s_d.left  = s_q.left - 1'b1;
            s_d.idx   = s_q.idx + 1'b1;
        end else if (lane_ready) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_rd_en0   = load && !start;
    assign mem_rd_en1   = load && !start && s_q.two;
    assign mem_rd_addr0 = s_q.base0 + AW'(s_q.idx);
    assign mem_rd_addr1 = s_q.base1 + AW'(s_q.idx);
    assign lane_valid   = s_q.valid;
    assign lane_seg0    = s_q.d0;
    assign lane_seg1    = s_q.d1;
    assign lane_mask    = s_q.mask;
    assign rd_idle      = (s_q.left == '0) && !s_q.valid;

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid && !lane_ready |=> lane_valid && $stable(lane_seg0) && $stable(lane_seg1) && $stable(lane_mask)); // R6
    AST_ONE_SRC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lane_valid && !s_q.two |-> lane_seg1 == '0); // R3
endmodule

// File: rtl/smdma_wr_chan.sv
module smdma_wr_chan #(
    parameter int SEG_BYTES = 64,
    parameter int AW        = 12,
    parameter int NW        = 11,
    localparam int SEG_W    = SEG_BYTES * 8,
    localparam int OFF_W    = $clog2(SEG_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NW-1:0]        nseg,
    input  logic [OFF_W-1:0]     tail,
    input  logic [AW-1:0]        base,
    input  logic                 res_valid,
    output logic                 res_ready,
    input  logic [SEG_W-1:0]     res_data,
    output logic                 mem_wr_en,
    output logic [AW-1:0]        mem_wr_addr,
    output logic [SEG_W-1:0]     mem_wr_data,
    output logic [SEG_BYTES-1:0] mem_wr_mask,
    output logic                 wr_idle
);
    typedef struct packed {
        logic [NW-1:0]    left;
        logic [NW-1:0]    idx;
        logic [AW-1:0]    base;
        logic [OFF_W-1:0] tail;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      accept;

    smdma_tail_mask #(.SEG_BYTES(SEG_BYTES)) u_mask (
        .is_last (s_q.left == NW'(1)),
        .tail    (s_q.tail),
        .mask    (mem_wr_mask)
    );

    always_comb begin
        s_d    = s_q;
        accept = res_valid && (s_q.left != '0);
        if (start) begin
            s_d.left = nseg;
            s_d.idx  = '0;
            s_d.base = base;
            s_d.tail = tail;
        end else if (accept) begin
            s_d.left = s_q.left - 1'b1;
            s_d.idx  = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign res_ready   = (s_q.left != '0);
    assign mem_wr_en   = accept;
    assign mem_wr_addr = s_q.base + AW'(s_q.idx);
    assign mem_wr_data = res_data;
    assign wr_idle     = (s_q.left == '0);

    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en && (s_q.left > NW'(1)) |=> !mem_wr_en || (mem_wr_addr == $past(mem_wr_addr) + 1'b1)); // R8
endmodule

// File: rtl/smdma_top.sv
module smdma_top
    import smdma_pkg::*;
#(
    parameter int SEG_BYTES = 64,
    parameter int AW        = 12,
    parameter int LEN_W     = 16,
    localparam int SEG_W    = SEG_BYTES * 8,
    localparam int OFF_W    = $clog2(SEG_BYTES),
    localparam int NW       = LEN_W - OFF_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic [1:0]           cfg_src_mode,
    input  logic [AW-1:0]        cfg_src0_base,
    input  logic [AW-1:0]        cfg_src1_base,
    input  logic [AW-1:0]        cfg_dst_base,
    input  logic [LEN_W-1:0]     cfg_vlen,
    output logic                 cfg_reject,
    output logic                 done,
    output logic                 mem_rd_en0,
    output logic [AW-1:0]        mem_rd_addr0,
    input  logic [SEG_W-1:0]     mem_rd_data0,
    output logic                 mem_rd_en1,
    output logic [AW-1:0]        mem_rd_addr1,
    input  logic [SEG_W-1:0]     mem_rd_data1,
    output logic                 lane_valid,
    input  logic                 lane_ready,
    output logic [SEG_W-1:0]     lane_seg0,
    output logic [SEG_W-1:0]     lane_seg1,
    output logic [SEG_BYTES-1:0] lane_mask,
    input  logic                 res_valid,
    output logic                 res_ready,
    input  logic [SEG_W-1:0]     res_data,
    output logic                 mem_wr_en,
    output logic [AW-1:0]        mem_wr_addr,
    output logic [SEG_W-1:0]     mem_wr_data,
    output logic [SEG_BYTES-1:0] mem_wr_mask
);
    typedef struct packed {
        logic busy;
        logic done;
        logic reject;
    } ctl_state_t;

    ctl_state_t       s_d, s_q;
    logic             start;
    logic             rd_idle, wr_idle;
    logic [LEN_W:0]   vlen_up;
    logic [NW-1:0]    nseg;
    logic [OFF_W-1:0] tail;

    assign vlen_up = {1'b0, cfg_vlen} + (LEN_W+1)'(SEG_BYTES - 1);
    assign nseg    = vlen_up[LEN_W:OFF_W];
    assign tail    = cfg_vlen[OFF_W-1:0];
    assign start   = cfg_valid && !s_q.busy;

    smdma_rd_chan #(.SEG_BYTES(SEG_BYTES), .AW(AW), .NW(NW)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mode         (src_mode_e'(cfg_src_mode)),
        .nseg         (nseg),
        .tail         (tail),
        .base0        (cfg_src0_base),
        .base1        (cfg_src1_base),
        .mem_rd_en0   (mem_rd_en0),
        .mem_rd_addr0 (mem_rd_addr0),
        .mem_rd_data0 (mem_rd_data0),
        .mem_rd_en1   (mem_rd_en1),
        .mem_rd_addr1 (mem_rd_addr1),
        .mem_rd_data1 (mem_rd_data1),
        .lane_valid   (lane_valid),
        .lane_ready   (lane_ready),
        .lane_seg0    (lane_seg0),
        .lane_seg1    (lane_seg1),
        .lane_mask    (lane_mask),
        .rd_idle      (rd_idle)
    );

    smdma_wr_chan #(.SEG_BYTES(SEG_BYTES), .AW(AW), .NW(NW)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .nseg        (nseg),
        .tail        (tail),
        .base        (cfg_dst_base),
        .res_valid   (res_valid),
        .res_ready   (res_ready),
        .res_data    (res_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .mem_wr_mask (mem_wr_mask),
        .wr_idle     (wr_idle)
    );

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.reject = cfg_valid && s_q.busy;
        if (start) begin
            s_d.busy = 1'b1;
        end else if (s_q.busy && rd_idle && wr_idle) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done       = s_q.done;
    assign cfg_reject = s_q.reject;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_REJECT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && s_q.busy |=> cfg_reject); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> !lane_valid && !res_ready); // R1
endmodule

// File: tb/smdma_top_tb.sv
module smdma_top_tb;
    localparam int SB    = 8;
    localparam int AW    = 10;
    localparam int LEN_W = 10;
    localparam int SW    = SB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_valid = 1'b0;
    logic [1:0]    cfg_src_mode = '0;
    logic [AW-1:0] cfg_src0_base = '0, cfg_src1_base = '0, cfg_dst_base = '0;
    logic [LEN_W-1:0] cfg_vlen = '0;
    logic          cfg_reject, done;
    logic          mem_rd_en0, mem_rd_en1, mem_wr_en;
    logic [AW-1:0] mem_rd_addr0, mem_rd_addr1, mem_wr_addr;
    logic [SW-1:0] mem_rd_data0, mem_rd_data1, mem_wr_data;
    logic          lane_valid, res_ready;
    logic          lane_ready = 1'b0, res_valid = 1'b0;
    logic [SW-1:0] lane_seg0, lane_seg1, res_data = '0;
    logic [SB-1:0] lane_mask, mem_wr_mask;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    function automatic logic [SW-1:0] rpat(input int a, input int p);
        logic [SW-1:0] r;
        for (int b = 0; b < SB; b++) r[b*8 +: 8] = 8'(a*5 + p*97 + b*3 + 1);
        return r;
    endfunction

    function automatic logic [SW-1:0] wpat(input int k, input int t);
        logic [SW-1:0] r;
        for (int b = 0; b < SB; b++) r[b*8 +: 8] = 8'(k*11 + t*7 + b + 200);
        return r;
    endfunction

    function automatic logic [SB-1:0] emask(input int k, input int ns, input int vl);
        logic [SB-1:0] m;
        int rem;
        rem = vl % SB;
        m = '1;
        if (k == ns - 1 && rem != 0) m = SB'((1 << rem) - 1);
        return m;
    endfunction

    function automatic bit pat_on(input int p, input int t);
        if (p == 0) return 1'b1;
        if (p == 1) return (t % 2) == 0;
        return (t % 3) != 2;
    endfunction

    assign mem_rd_data0 = rpat(int'(mem_rd_addr0), 0);
    assign mem_rd_data1 = rpat(int'(mem_rd_addr1), 1);

    smdma_top #(.SEG_BYTES(SB), .AW(AW), .LEN_W(LEN_W)) u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic run_one(input int tn, input int vl, input int mode, input int p, input bit inject);
        int ns, nrd, rk, wk, last_r, last_w, t, dcnt, exp_done, after;
        int b0, b1, bd;
        bit first_seen, stop;
        ns = (vl + SB - 1) / SB;
        nrd = (mode == 0) ? 0 : ns;
        b0 = (tn * 3) % 512; b1 = 600 + tn % 100; bd = 300 + tn % 200;
        @(negedge clk);
        cfg_valid = 1'b1; cfg_src_mode = 2'(mode); cfg_vlen = LEN_W'(vl);
        cfg_src0_base = AW'(b0); cfg_src1_base = AW'(b1); cfg_dst_base = AW'(bd);
        @(posedge clk);
        rk = 0; wk = 0; last_r = -1; last_w = -1; dcnt = 0; after = 0;
        first_seen = 0; stop = 0;
        for (t = 0; t < 200 && !stop; t++) begin
            @(negedge clk);
            cfg_valid = inject && (t == 2);
            if (cfg_valid) begin
                cfg_src0_base = AW'(77); cfg_src1_base = AW'(88); cfg_dst_base = AW'(99);
            end
            lane_ready = pat_on(p, t);
            res_valid  = pat_on((p + 1) % 3, t + 1) && (wk < ns);
            res_data   = wpat(wk, tn);
            #1;
            if (inject && t == 3) chk(cfg_reject == 1'b1, "R2 reject after busy cfg", SW'(cfg_reject), 1);
            if (t == 0) chk(cfg_reject == 1'b0, "R2 no reject on idle cfg", SW'(cfg_reject), 0);
            if (mode < 2) chk(mem_rd_en1 == 1'b0, "R3 source 1 unread", SW'(mem_rd_en1), 0);
            if (p == 0 && first_seen && rk < nrd)
                chk(lane_valid == 1'b1, "R7 back-to-back segments", SW'(lane_valid), 1);
            if (lane_valid) begin
                first_seen = 1;
                chk(rk < nrd, "R6 no extra segment", SW'(rk), SW'(nrd));
                chk(lane_seg0 == rpat(int'(AW'(b0 + rk)), 0), "R4 R1 source 0 segment", lane_seg0, rpat(int'(AW'(b0 + rk)), 0));
                chk(lane_seg1 == ((mode == 2) ? rpat(int'(AW'(b1 + rk)), 1) : '0), "R3 source 1 segment",
                    lane_seg1, (mode == 2) ? rpat(int'(AW'(b1 + rk)), 1) : '0);
                chk(lane_mask == emask(rk, ns, vl), "R5 read mask", SW'(lane_mask), SW'(emask(rk, ns, vl)));
                if (lane_ready) begin rk++; last_r = t; end
            end
            chk(res_ready == (wk < ns), "R8 res_ready", SW'(res_ready), SW'(wk < ns));
            if (res_valid && res_ready) begin
                chk(mem_wr_en == 1'b1, "R8 write strobe", SW'(mem_wr_en), 1);
                chk(mem_wr_addr == AW'(bd + wk), "R8 R1 write address", SW'(mem_wr_addr), SW'(AW'(bd + wk)));
                chk(mem_wr_data == wpat(wk, tn), "R8 write data", mem_wr_data, wpat(wk, tn));
                chk(mem_wr_mask == emask(wk, ns, vl), "R5 write mask", SW'(mem_wr_mask), SW'(emask(wk, ns, vl)));
                wk++; last_w = t;
            end else begin
                chk(mem_wr_en == 1'b0, "R8 no write without handshake", SW'(mem_wr_en), 0);
            end
            if (done) begin
                dcnt++;
                exp_done = ((last_r > last_w) ? last_r : last_w) + 2;
                chk(dcnt == 1, "R9 single done", SW'(dcnt), 1);
                chk(t == exp_done, "R9 done timing", SW'(t), SW'(exp_done));
                chk(rk == nrd && wk == ns, "R9 done after all transfers", SW'(rk), SW'(nrd));
            end
            if (dcnt > 0) begin
                after++;
                if (after > 3) stop = 1;
            end
        end
        chk(dcnt == 1, "R9 done seen once", SW'(dcnt), 1);
        lane_ready = 1'b0; res_valid = 1'b0; cfg_valid = 1'b0;
    endtask

    initial begin : main
        int tn;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(lane_valid == 0 && res_ready == 0 && done == 0 && cfg_reject == 0, "R10 reset outputs", SW'(lane_valid), 0);
        chk(mem_rd_en0 == 0 && mem_rd_en1 == 0 && mem_wr_en == 0, "R10 reset strobes", SW'(mem_wr_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lane_valid == 0 && res_ready == 0, "R1 idle quiet", SW'(res_ready), 0);
        tn = 0;
        for (int vl = 0; vl <= 5 * SB; vl++)
            for (int mode = 0; mode < 3; mode++)
                for (int p = 0; p < 3; p++) begin
                    run_one(tn, vl, mode, p, (vl == 5 * SB) && (mode == 2) && (p == 1));
                    tn++;
                end
        @(negedge clk);
        chk(lane_valid == 0 && res_ready == 0, "R1 idle after runs", SW'(lane_valid), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule